// File: doc/BRIEF.md
# Priority Encoded Restart Opcode Responder

This block sits between eight interrupting devices and a processor that has one request pin with no vector of its own. Each device raises a request line. The block remembers every request it sees and picks the highest-numbered pending source. It raises a single interrupt request toward the processor. When the processor answers with its active-low acknowledge strobe, the block drives a one-byte restart opcode onto the data bus. The processor runs that opcode as a call to a fixed vector, which is eight times the source number.

The winning index is frozen when acknowledge falls, so late requests cannot corrupt the opcode while it is being read. The interrupt request is withdrawn while acknowledge is active, so the same event cannot fire twice. The acknowledged source's pending bit is cleared when acknowledge rises. Any source that is still pending then raises the request again. The data path is a strobe-qualified bus with a drive enable, not a valid/ready stream: the processor cannot stall it, and the opcode stays valid for as long as the strobe is held low. All inputs are sampled on the rising clock edge.

Top module: `rst_vec_responder`

## Requirements
- R1: While reset is active and right after it, `irq`, `bus_oe`, `bus_data` and `sel_idx` are all zero, and all pending requests are discarded.
- R2: While `ack_n` is high, `sel_idx` gives the highest pending source number, where source 7 has the top priority and source 0 the lowest.
- R3: While `ack_n` is low, `bus_oe` is 1 and `bus_data` equals binary 11nnn111, where nnn is the held index. Source 0 gives C7h and source 7 gives FFh.
- R4: The opcode on the bus selects the vector address 8×n: `bus_data` masked with 38h equals 8 times the acknowledged source number.
- R5: A request that is high for one clock makes `irq` high from the next cycle. `irq` then stays high for any length of time (tested well beyond 18 cycles) until acknowledge arrives, even if the device drops its line.
- R6: `irq` is low in every cycle in which `ack_n` is low.
- R7: The index sampled in the last cycle before `ack_n` falls is held on `sel_idx` and in the opcode for as long as `ack_n` stays low, even if higher-priority requests arrive meanwhile.
- R8: In the cycle in which `ack_n` returns high, `irq` stays low and the acknowledged source's pending bit is cleared. From the next cycle, `irq` is high again if other sources are still pending, and `sel_idx` shows the next winner.
- R9: While `ack_n` is high, `bus_oe` is 0 and `bus_data` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_req | input | 8 | Request lines from the devices, active high; bit 7 has the top priority |
| ack_n | input | 1 | Interrupt acknowledge strobe from the processor, active low |
| irq | output | 1 | Interrupt request to the processor, active high |
| bus_data | output | 8 | Restart opcode, valid while `bus_oe` is 1 |
| bus_oe | output | 1 | Data bus drive enable |
| sel_idx | output | 3 | Selected source number |

## Verification
The assertions check, on every cycle, the properties that hold at any moment. While the bus is driven, the opcode is always 11nnn111 around the shown index. The index does not move while acknowledge stays low. `irq` never drops except when acknowledge arrives. A cleared pending bit is really empty on the following cycle. The encoder's choice is always the top set bit. Only the bench scenarios can show the ordering effects. These are: the order in which several pending sources are served one after another, that a request pulsed once survives a long wait, that a request arriving during acknowledge is served after the current one, and that a reset in the middle of a run discards pending work. The bench also checks the vector address implied by each opcode against a separate model.

// File: rtl/rst_vec_pkg.sv
package rst_vec_pkg;
  localparam int SRC_N    = 8;
  localparam int SRC_IW   = $clog2(SRC_N);
  localparam int BUS_W    = 8;
  // Fixed bits of the restart opcode and where the index lands in it
  localparam logic [BUS_W-1:0] OP_BASE = 8'hC7;
  localparam int               OP_LSB  = 3;
endpackage

// File: rtl/ack_tracker.sv
module ack_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_n,
  output logic ack_on,
  output logic ack_rise,
  output logic ack_idle
);
  logic ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b1;
    else        ack_q <= ack_n;
  end

  assign ack_on   = ~ack_n;
  assign ack_rise = ack_n & ~ack_q;
  assign ack_idle = ack_n & ack_q;
endmodule

// File: rtl/pend_bank.sv
module pend_bank #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  set_vec,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  output logic [N-1:0]  pend
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic hit;
    assign hit = clr_en && (clr_idx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pend[g] <= 1'b0;
      else if (hit) pend[g] <= 1'b0;
      else          pend[g] <= pend[g] | set_vec[g];
    end
  end

  // R8: an acknowledged source is empty on the cycle after its clear
  p_pend_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !pend[$past(clr_idx)]);
endmodule

// File: rtl/top_prio_enc.sv
module top_prio_enc #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (vec_i[i]) begin
        idx_o = IW'(i);
        any_o = 1'b1;
      end
    end
    // R2: the chosen bit is set and no higher bit is set
    if (any_o) begin
      p_enc_top_r2: assert ((vec_i >> idx_o) == {{(N-1){1'b0}}, 1'b1});
    end
  end
endmodule

// File: rtl/rst_vec_responder.sv
module rst_vec_responder
  import rst_vec_pkg::*;
#(
  parameter int               N       = SRC_N,
  parameter int               DW      = BUS_W,
  parameter logic [DW-1:0]    BASE_OP = OP_BASE,
  parameter int               IDX_LSB = OP_LSB,
  localparam int              IW      = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  dev_req,
  input  logic          ack_n,
  output logic          irq,
  output logic [DW-1:0] bus_data,
  output logic          bus_oe,
  output logic [IW-1:0] sel_idx
);
  logic          ack_on, ack_rise, ack_idle;
  logic [N-1:0]  pend;
  logic [IW-1:0] win_idx, held_idx;
  logic          win_any;

  ack_tracker u_ack (
    .clk(clk), .rst_n(rst_n), .ack_n(ack_n),
    .ack_on(ack_on), .ack_rise(ack_rise), .ack_idle(ack_idle)
  );

  pend_bank #(.N(N), .IW(IW)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_vec(dev_req),
    .clr_en(ack_rise), .clr_idx(held_idx), .pend(pend)
  );

  top_prio_enc #(.N(N), .IW(IW)) u_enc (
    .vec_i(pend), .idx_o(win_idx), .any_o(win_any)
  );

  // Tracks the winner while idle; freezes once acknowledge is low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     held_idx <= '0;
    else if (ack_n) held_idx <= win_idx;
  end

  assign irq      = win_any & ack_idle;
  assign sel_idx  = ack_on ? held_idx : win_idx;
  assign bus_oe   = ack_on;
  assign bus_data = ack_on ? (BASE_OP | (DW'(held_idx) << IDX_LSB)) : '0;

  // R3: opcode form while driven
  p_opcode_form_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (bus_data[IDX_LSB +: IW] == sel_idx) &&
               ((bus_data & ~(DW'((1 << IW) - 1) << IDX_LSB)) == BASE_OP));

  // R7: index frozen through a held acknowledge
  p_idx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && $past(!ack_n)) |-> $stable(sel_idx));

  // R5: request only withdrawn by an acknowledge
  p_irq_persist_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && ack_n) |=> (irq || !ack_n));

  // R6: no request while acknowledge is active
  p_irq_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> !irq);
endmodule

// File: tb/rst_vec_responder_tb_top.sv
`timescale 1ns/1ps
module rst_vec_responder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] dev_req = '0;
  logic       ack_n = 1'b1;
  logic       irq, bus_oe;
  logic [7:0] bus_data;
  logic [2:0] sel_idx;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rst_vec_responder dut_i (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .ack_n(ack_n),
    .irq(irq), .bus_data(bus_data), .bus_oe(bus_oe), .sel_idx(sel_idx)
  );

  // {request pattern, expected first winner}
  localparam logic [10:0] VECS [8] = '{
    {8'h01, 3'd0}, {8'h80, 3'd7}, {8'h3C, 3'd5}, {8'hFF, 3'd7},
    {8'h12, 3'd4}, {8'h41, 3'd6}, {8'h06, 3'd2}, {8'h28, 3'd5}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int top_bit(input logic [7:0] v);
    int r = -1;
    for (int i = 0; i < 8; i++) if (v[i]) r = i;
    return r;
  endfunction

  // One full acknowledge of source e; rem is what stays pending afterwards
  task automatic ack_one(input int e, input logic [7:0] rem);
    @(negedge clk); ack_n = 1'b0; #1;
    chk("R6 irq low in ack", int'(irq), 0);
    chk("R3 bus_oe in ack", int'(bus_oe), 1);
    chk("R3 opcode", int'(bus_data), 8'hC7 | (e << 3));
    chk("R4 vector addr", int'(bus_data & 8'h38), 8 * e);
    chk("R7 held idx", int'(sel_idx), e);
    @(negedge clk); ack_n = 1'b1; #1;
    chk("R8 irq low on release", int'(irq), 0);
    @(negedge clk); #1;
    chk("R8 irq re-raise", int'(irq), int'(rem != 0));
    if (rem != 0) chk("R8 next winner", int'(sel_idx), top_bit(rem));
    chk("R9 bus idle", int'({bus_oe, bus_data}), 0);
  endtask

  task automatic drain(input logic [7:0] v);
    logic [7:0] rem = v;
    while (rem != 0) begin
      int e = top_bit(rem);
      rem[e] = 1'b0;
      ack_one(e, rem);
    end
  endtask

  initial begin
    // R1: during reset
    #1;
    chk("R1 irq in reset", int'(irq), 0);
    chk("R1 bus in reset", int'({bus_oe, bus_data}), 0);
    chk("R1 idx in reset", int'(sel_idx), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 irq after reset", int'(irq), 0);

    // Table walk: R2, R3, R4, R5, R8, R9
    for (int v = 0; v < 8; v++) begin
      @(negedge clk); dev_req = VECS[v][10:3];
      @(negedge clk); dev_req = '0; #1;
      chk("R5 irq raised", int'(irq), 1);
      chk("R2 winner", int'(sel_idx), int'(VECS[v][2:0]));
      chk("R9 bus idle", int'({bus_oe, bus_data}), 0);
      drain(VECS[v][10:3]);
    end

    // R5: one-cycle pulse must survive a long wait
    @(negedge clk); dev_req = 8'h01;
    @(negedge clk); dev_req = '0;
    begin
      bit held = 1'b1;
      repeat (40) begin @(negedge clk); #1; if (irq !== 1'b1) held = 1'b0; end
      chk("R5 irq held 40 cycles", int'(held), 1);
    end
    drain(8'h01);

    // R7: higher request arriving during acknowledge
    @(negedge clk); dev_req = 8'h04;
    @(negedge clk); dev_req = '0;
    @(negedge clk); ack_n = 1'b0; dev_req = 8'h80; #1;
    chk("R7 idx at ack start", int'(sel_idx), 2);
    @(negedge clk); dev_req = '0; #1;
    chk("R7 idx held", int'(sel_idx), 2);
    chk("R7 opcode held", int'(bus_data), 8'hD7);
    @(negedge clk); ack_n = 1'b1; #1;
    chk("R8 irq low on release", int'(irq), 0);
    @(negedge clk); #1;
    chk("R8 late source raised", int'(irq), 1);
    chk("R8 late source idx", int'(sel_idx), 7);
    drain(8'h80);

    // R1: reset in the middle discards pending work
    @(negedge clk); dev_req = 8'h50;
    @(negedge clk); dev_req = '0; rst_n = 1'b0; #1;
    chk("R1 irq cleared by reset", int'(irq), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 pending discarded", int'(irq), 0);
    chk("R1 idx after reset", int'(sel_idx), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule